// File: doc/BRIEF.md
# Lowcore Prefix Address Swapper

This block turns a real address issued by one processor core into an absolute address. Each core owns an 8 KiB housekeeping area, and its base is held in a loadable prefix register. The lowest 8 KiB of real storage and the 8 KiB window at the prefix base swap places. Every other address passes through unchanged.

Each request is one address with a valid strobe. The request carries an addressing mode that selects 24-, 31- or 64-bit addressing. Address bits beyond the selected width are cleared before the swap. The absolute address is registered and appears one cycle after the request. The prefix register is written through its own load port. It always holds an 8 KiB-aligned value.

Top module: `lps_prefix_swapper`

## Requirements
- R1: A masked real address whose bits above bit 12 are all zero maps to the prefix value with the low 13 address bits kept as the offset.
- R2: A masked real address that lies in the 8 KiB window starting at the prefix value maps to zero plus the same 13-bit offset.
- R3: A masked real address outside both windows appears unchanged at the output.
- R4: While the prefix register holds zero, the output equals the masked input for every address.
- R5: Mode code 2'b00 selects 24-bit addressing: input bits 63 down to 24 are treated as zero.
- R6: Mode code 2'b01 selects 31-bit addressing: input bits 63 down to 31 are treated as zero.
- R7: Mode codes 2'b10 and 2'b11 select 64-bit addressing: all 64 input bits take part.
- R8: A prefix load stores the load data with bits 12 down to 0 cleared. The new value applies to requests presented in the cycles after the load cycle. A request in the load cycle itself still uses the old prefix.
- R9: out_valid is high exactly in the cycle after a cycle with in_valid high. The address for that request is on out_addr in that same cycle.
- R10: While in_valid is low, out_addr holds its last value whatever in_addr and mode do.
- R11: During and after reset, and before any request or load, out_valid is 0, out_addr is 0 and the prefix is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Addressing mode: 00 = 24-bit, 01 = 31-bit, 1x = 64-bit |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Real address |
| pfx_load | input | 1 | Prefix register write enable |
| pfx_data | input | 64 | New prefix value (low 13 bits ignored) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_addr | output | 64 | Absolute address |

## Verification
On every cycle, the assertions check the following:
- out_valid trails in_valid by exactly one cycle.
- The 13-bit offset survives translation.
- out_addr stays frozen while no request is present.
- The prefix register changes only on a load, and it takes the upper bits of the load data.

Only the bench's scenarios can show the rest:
- the choice of window for each address, including the edges of both windows;
- the effect of each addressing mode on high address bits;
- the identity mapping under a zero prefix;
- that a load in the same cycle as a request does not affect that request.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    AM_24  = 2'b00,
    AM_31  = 2'b01,
    AM_64  = 2'b10,
    AM_64B = 2'b11
  } amode_t;
endpackage

// File: rtl/lps_mode_mask.sv
module lps_mode_mask #(
  parameter int ADDR_W = 64
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  import lps_pkg::*;

  localparam int NARROW_W = 24;
  localparam int MID_W    = 31;

  logic [ADDR_W-1:0] keep24;
  logic [ADDR_W-1:0] keep31;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    assign keep24[g] = (g < NARROW_W);
    assign keep31[g] = (g < MID_W);
  end

  always_comb begin
    unique case (amode_t'(mode))
      AM_24:   addr_o = addr_i & keep24;
      AM_31:   addr_o = addr_i & keep31;
      default: addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/lps_prefix_reg.sv
module lps_prefix_reg #(
  parameter int ADDR_W = 64,
  parameter int WIN_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] data,
  output logic [ADDR_W-1:0] pfx
);
  localparam int BLK_W = ADDR_W - WIN_W;

  logic [BLK_W-1:0] blk_q;
  logic [BLK_W-1:0] blk_d;

  always_comb begin
    blk_d = blk_q;
    if (load) blk_d = data[ADDR_W-1:WIN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= '0;
    else if (load) blk_q <= blk_d;
  end

  assign pfx = {blk_q, {WIN_W{1'b0}}};

  // R8
  pfx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pfx[ADDR_W-1:WIN_W] == $past(data[ADDR_W-1:WIN_W]));
  // R8
  pfx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pfx));
endmodule

// File: rtl/lps_window_swap.sv
module lps_window_swap #(
  parameter int ADDR_W = 64,
  parameter int WIN_W  = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pfx,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int BLK_W = ADDR_W - WIN_W;

  logic [BLK_W-1:0] blk;
  logic [BLK_W-1:0] pblk;
  logic [WIN_W-1:0] off;

  assign blk  = addr_i[ADDR_W-1:WIN_W];
  assign pblk = pfx[ADDR_W-1:WIN_W];
  assign off  = addr_i[WIN_W-1:0];

  always_comb begin
    if (blk == '0)        addr_o = {pblk, off};
    else if (blk == pblk) addr_o = {{BLK_W{1'b0}}, off};
    else                  addr_o = addr_i;
  end
endmodule

// File: rtl/lps_prefix_swapper.sv
module lps_prefix_swapper #(
  parameter int ADDR_W = 64,
  parameter int WIN_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              pfx_load,
  input  logic [ADDR_W-1:0] pfx_data,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [ADDR_W-1:0] masked;
  logic [ADDR_W-1:0] pfx;
  logic [ADDR_W-1:0] swapped;
  logic              vld_d;
  logic [ADDR_W-1:0] addr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  lps_mode_mask #(.ADDR_W(ADDR_W)) u_mask (
    .mode(mode), .addr_i(in_addr), .addr_o(masked)
  );

  lps_prefix_reg #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_pfx (
    .clk(clk), .rst_n(rst_s_n), .load(pfx_load), .data(pfx_data), .pfx(pfx)
  );

  lps_window_swap #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_swap (
    .addr_i(masked), .pfx(pfx), .addr_o(swapped)
  );

  always_comb begin
    vld_d  = in_valid;
    addr_d = out_addr;
    if (in_valid) addr_d = swapped;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) out_valid <= 1'b0;
    else          out_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      out_addr <= '0;
    else if (in_valid) out_addr <= addr_d;
  end

  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> out_valid);
  // R9
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> !out_valid);
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> $stable(out_addr));
  // R1
  off_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> out_addr[WIN_W-1:0] == $past(in_addr[WIN_W-1:0]));
endmodule

// File: tb/lps_prefix_swapper_bench.sv
`timescale 1ns/1ps
module lps_prefix_swapper_bench;
  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        in_valid;
  logic [63:0] in_addr;
  logic        pfx_load;
  logic [63:0] pfx_data;
  logic        out_valid;
  logic [63:0] out_addr;

  item_t       sb[$];
  logic [63:0] mdl_pfx;
  logic [63:0] last_exp;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  lps_prefix_swapper u_lps_prefix_swapper (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_addr(in_addr), .pfx_load(pfx_load), .pfx_data(pfx_data),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] a,
                                        input logic [63:0] p);
    logic [63:0] x;
    x = a;
    if (m == 2'b00) x = a & 64'h0000_0000_00FF_FFFF;
    else if (m == 2'b01) x = a & 64'h0000_0000_7FFF_FFFF;
    if (x[63:13] == 0) return p | {51'd0, x[12:0]};
    if (x[63:13] == p[63:13]) return {51'd0, x[12:0]};
    return x;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input string tag, input logic [1:0] m, input logic [63:0] a);
    item_t it;
    @(negedge clk);
    pfx_load = 1'b0;
    in_valid = 1'b1;
    mode     = m;
    in_addr  = a;
    it.exp   = model(m, a, mdl_pfx);
    it.tag   = tag;
    last_exp = it.exp;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    pfx_load = 1'b0;
    in_addr  = 64'hDEAD_BEEF_0000_0000;
    mode     = 2'b11;
  endtask

  task automatic load(input logic [63:0] d);
    @(negedge clk);
    in_valid = 1'b0;
    pfx_load = 1'b1;
    pfx_data = d;
    @(negedge clk);
    pfx_load = 1'b0;
    mdl_pfx  = d & ~64'h1FFF;
  endtask

  // Monitor: pop and compare whenever a result appears
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (out_valid === 1'b1) begin
        if (sb.size() == 0) check("R9 unexpected out_valid", out_valid, 1'b0);
        else begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, out_addr, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b10; in_valid = 1'b0; in_addr = '0;
    pfx_load = 1'b0; pfx_data = '0; mdl_pfx = '0; last_exp = '0;
    repeat (4) @(negedge clk);
    check("R11 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R11 out_addr in reset", out_addr, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R11 out_addr after reset", out_addr, 64'd0);

    // prefix zero after reset: identity
    req("R4 R11 zero prefix low", 2'b10, 64'h100);
    req("R4 zero prefix window top", 2'b10, 64'h1FFF);
    req("R4 zero prefix high", 2'b10, 64'h5_0000_2000);
    idle();

    load(64'h0000_0000_0012_3456);   // stored 0x122000 (R8)
    req("R1 base", 2'b10, 64'h0);
    req("R1 window top", 2'b10, 64'h1FFF);
    req("R2 inside prefix", 2'b10, 64'h0012_2010);
    req("R2 prefix top", 2'b10, 64'h0012_3FFF);
    req("R3 above prefix", 2'b10, 64'h0012_4000);
    req("R3 below prefix", 2'b10, 64'h0012_1FFF);
    req("R3 just above low window", 2'b10, 64'h2000);
    req("R8 low bits dropped", 2'b10, 64'h0012_2000);
    idle();

    req("R5 24-bit to prefix window", 2'b00, 64'hFF00_0000_0012_2040);
    req("R5 24-bit to low window", 2'b00, 64'hABCD_0000_0000_0010);
    req("R6 31-bit to low window", 2'b01, 64'h8000_0000_8000_0005);
    req("R6 31-bit pass", 2'b01, 64'hFFFF_FFFF_7FFF_0000);
    req("R7 64-bit high bit kept", 2'b10, 64'h8000_0000_0000_0005);
    req("R7 mode 11 high bits kept", 2'b11, 64'h0000_0001_0012_2008);
    req("R7 64-bit prefix window", 2'b11, 64'h0012_2008);
    idle();

    // R10: hold while idle
    req("R10 setup", 2'b10, 64'h7777_0000);
    idle();
    repeat (3) @(negedge clk);
    check("R10 out_addr holds", out_addr, last_exp);
    check("R9 out_valid low when idle", {63'd0, out_valid}, 64'd0);

    // R8: load and request in the same cycle use the old prefix
    begin
      item_t it;
      @(negedge clk);
      in_valid = 1'b1; mode = 2'b10; in_addr = 64'h10;
      pfx_load = 1'b1; pfx_data = 64'h4000_0000_0000_1FFF;
      it.exp = model(2'b10, 64'h10, mdl_pfx);
      it.tag = "R8 same-cycle old prefix";
      sb.push_back(it);
      @(negedge clk);
      in_valid = 1'b0; pfx_load = 1'b0;
      mdl_pfx = 64'h4000_0000_0000_0000;
    end
    req("R8 new prefix applies", 2'b10, 64'h10);
    req("R2 new prefix window", 2'b10, 64'h4000_0000_0000_0123);
    req("R3 old prefix window now passes", 2'b10, 64'h0012_2010);
    idle();

    load(64'h0000_0000_0000_1ABC);   // stored 0
    req("R4 reloaded zero", 2'b10, 64'h123);
    req("R4 reloaded zero high", 2'b10, 64'h4000_0000_0000_0123);
    idle();
    repeat (3) @(negedge clk);
    check("R9 all results delivered", 64'(sb.size()), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule